// File: doc/BRIEF.md
# Pixel Row Zero-Suppression Pipeline

This block reduces the data volume of one readout row of pixel samples. Samples come in as a group of 32, each tagged with a pixel index. In suppression mode the block subtracts the stored baseline of each pixel. It can then remove a shared offset from the whole group, and it forwards only the pixels whose corrected value is above a hit threshold. A bypass mode forwards every sample untouched, for calibration and debug.

The shared offset is estimated in two passes over a buffered copy of the group. The first pass takes the plain mean of the baseline-corrected values. The second pass replaces every value lying more than a margin above that mean with the mean itself, then averages again. This keeps real signals from dragging the estimate upwards. A group takes 32 input cycles to load, 32 cycles for the clipping pass and 32 cycles to emit. The input is stalled while the two later phases run. Each group ends with an end-of-group marker, even when no pixel passes the threshold.

Top module: `zs_pipeline`

## Requirements
- R1: With `cfg_raw`=1, each accepted sample appears one cycle later with `out_valid`=1, the same index and the sample value zero-extended. `out_last`=1 on the 32nd sample of a group.
- R2: In suppression mode the baseline is read combinationally from `ped_data` at address `ped_addr`=`in_idx`, and each value is taken as sample minus baseline.
- R3: With `cfg_cm_en`=0, no offset is removed and the emitted value equals sample minus baseline.
- R4: The first estimate is the sum of the 32 corrected values, shifted right arithmetically by 5 (the floor of the mean).
- R5: With `cfg_cm_en`=1, a value strictly greater than first estimate plus `cfg_margin` counts as the first estimate. The floor mean of these values is the final offset and is subtracted from every value. The final offset never exceeds the first estimate.
- R6: A suppression-mode record has `out_valid`=1 only when its corrected value, compared as signed, is strictly greater than `cfg_thr`.
- R7: A corrected value outside the signed 11-bit range saturates to 1023 or -1024.
- R8: After the last pixel of a suppression group, exactly one cycle has `out_last`=1. `out_valid` on that cycle shows whether that pixel is a hit.
- R9: In suppression mode `in_ready` falls after the 32nd sample and stays low for exactly 64 cycles. Records leave in arrival order.
- R10: During and after reset, `out_valid`=0, `out_last`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_raw | input | 1 | 1 selects bypass mode |
| cfg_cm_en | input | 1 | 1 enables offset removal |
| cfg_margin | input | 11 | Unsigned clipping margin above the first estimate |
| cfg_thr | input | 11 | Signed hit threshold |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_idx | input | 8 | Pixel index of the sample |
| in_sample | input | 10 | Unsigned sample |
| ped_addr | output | 8 | Baseline lookup address |
| ped_data | input | 10 | Baseline of the addressed pixel, same cycle |
| out_valid | output | 1 | Record carries a forwarded pixel |
| out_last | output | 1 | End-of-group marker |
| out_idx | output | 8 | Pixel index of the record |
| out_value | output | 11 | Signed corrected value, or raw sample in bypass |

## Verification
The assertions assume that the configuration inputs hold still from the first sample of a group until its end marker. They also assume that the mode changes only between whole groups, so the group counter is at zero at every boundary. The stimulus sets the configuration only while the block is idle, sends each group as exactly 32 samples, and waits for the end marker before starting the next group. The stimulus patterns cover a common positive offset with large hits, a negative offset, values on both sides of the threshold, and a group whose offset is strongly negative, so that the upper saturation limit is reached.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_CLIP = 2'd1,
    ST_EMIT = 2'd2
  } zs_state_e;
endpackage

// File: rtl/zs_rst_sync.sv
module zs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/zs_pedsub.sv
module zs_pedsub #(
  parameter int SAMPLE_W = 10,
  parameter int VAL_W    = 11
) (
  input  logic [SAMPLE_W-1:0]     sample,
  input  logic [SAMPLE_W-1:0]     pedestal,
  output logic signed [VAL_W-1:0] diff
);
  localparam int DW = SAMPLE_W + 1;

  logic signed [DW-1:0] wide_diff;
  assign wide_diff = $signed({1'b0, sample}) - $signed({1'b0, pedestal});

  generate
    if (VAL_W >= DW) begin : g_fit
      assign diff = VAL_W'(wide_diff);
    end else begin : g_clamp
      localparam logic signed [DW-1:0] LIM_HI = DW'((2 ** (VAL_W - 1)) - 1);
      localparam logic signed [DW-1:0] LIM_LO = -LIM_HI - DW'(1);
      always_comb begin
        if (wide_diff > LIM_HI)      diff = LIM_HI[VAL_W-1:0];
        else if (wide_diff < LIM_LO) diff = LIM_LO[VAL_W-1:0];
        else                         diff = wide_diff[VAL_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/zs_cm_acc.sv
module zs_cm_acc #(
  parameter int VAL_W = 11,
  parameter int N_PIX = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc1_en,
  input  logic                    acc2_en,
  input  logic                    first,
  input  logic signed [VAL_W-1:0] val,
  input  logic [VAL_W-1:0]        margin,
  output logic signed [VAL_W-1:0] mean1,
  output logic signed [VAL_W-1:0] mean2
);
  localparam int CNT_W = $clog2(N_PIX);
  localparam int SUM_W = VAL_W + CNT_W;
  localparam int CMP_W = VAL_W + 2;

  logic signed [SUM_W-1:0] sum1_q, sum1_d, sum2_q, sum2_d;
  logic signed [CMP_W-1:0] clip_lim;
  logic signed [VAL_W-1:0] clipped;

  assign mean1 = VAL_W'(sum1_q >>> CNT_W);
  assign mean2 = VAL_W'(sum2_q >>> CNT_W);

  // Outlier clipping for the second pass
  assign clip_lim = CMP_W'(mean1) + $signed({2'b00, margin});
  assign clipped  = (CMP_W'(val) > clip_lim) ? mean1 : val;

  always_comb begin
    sum1_d = sum1_q;
    sum2_d = sum2_q;
    if (acc1_en) sum1_d = (first ? '0 : sum1_q) + SUM_W'(val);
    if (acc2_en) sum2_d = (first ? '0 : sum2_q) + SUM_W'(clipped);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum1_q <= '0;
      sum2_q <= '0;
    end else begin
      if (acc1_en) sum1_q <= sum1_d;
      if (acc2_en) sum2_q <= sum2_d;
    end
  end

  // R4: a fresh group restarts the first sum at the incoming value
  p_sum_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc1_en && first) |=> (sum1_q == SUM_W'($past(val))));
endmodule

// File: rtl/zs_hit_sel.sv
module zs_hit_sel #(
  parameter int VAL_W = 11
) (
  input  logic signed [VAL_W-1:0] val,
  input  logic signed [VAL_W-1:0] cm,
  input  logic                    cm_en,
  input  logic signed [VAL_W-1:0] thr,
  output logic signed [VAL_W-1:0] corr,
  output logic                    hit
);
  localparam logic signed [VAL_W:0] W_MAX = {2'b00, {(VAL_W-1){1'b1}}};
  localparam logic signed [VAL_W:0] W_MIN = {2'b11, {(VAL_W-1){1'b0}}};

  logic signed [VAL_W:0] wide;
  assign wide = (VAL_W+1)'(val) - (cm_en ? (VAL_W+1)'(cm) : '0);

  always_comb begin
    if (wide > W_MAX)      corr = W_MAX[VAL_W-1:0];
    else if (wide < W_MIN) corr = W_MIN[VAL_W-1:0];
    else                   corr = wide[VAL_W-1:0];
  end

  assign hit = (corr > thr);
endmodule

// File: rtl/zs_pipeline.sv
module zs_pipeline
  import zs_pkg::*;
#(
  parameter int N_PIX    = 32,
  parameter int SAMPLE_W = 10,
  parameter int VAL_W    = 11,
  parameter int IDX_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_raw,
  input  logic                    cfg_cm_en,
  input  logic [VAL_W-1:0]        cfg_margin,
  input  logic signed [VAL_W-1:0] cfg_thr,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [SAMPLE_W-1:0]     in_sample,
  output logic [IDX_W-1:0]        ped_addr,
  input  logic [SAMPLE_W-1:0]     ped_data,
  output logic                    out_valid,
  output logic                    out_last,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [VAL_W-1:0] out_value
);
  localparam int CNT_W = $clog2(N_PIX);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(N_PIX - 1);

  logic rst_s;
  zs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  zs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, last_slot, first;
  logic             buf_we, acc1_en, acc2_en;

  logic signed [VAL_W-1:0] val_buf [N_PIX];
  logic [IDX_W-1:0]        idx_buf [N_PIX];
  logic signed [VAL_W-1:0] cur_val, diff, mean1, mean2, corr;
  logic [IDX_W-1:0]        cur_idx;
  logic                    hit;

  logic                    ov_q, ov_d, ol_q, ol_d, oraw_q, oraw_d;
  logic [IDX_W-1:0]        oi_q, oi_d;
  logic signed [VAL_W-1:0] oval_q, oval_d;

  assign ped_addr  = in_idx;
  assign in_ready  = (state_q == ST_LOAD);
  assign accept    = in_valid & in_ready;
  assign last_slot = (cnt_q == CNT_END);
  assign first     = (cnt_q == '0);
  assign cur_val   = val_buf[cnt_q];
  assign cur_idx   = idx_buf[cnt_q];

  zs_pedsub #(.SAMPLE_W(SAMPLE_W), .VAL_W(VAL_W)) u_pedsub (
    .sample(in_sample), .pedestal(ped_data), .diff(diff)
  );

  zs_cm_acc #(.VAL_W(VAL_W), .N_PIX(N_PIX)) u_cm (
    .clk(clk), .rst_n(rst_s), .acc1_en(acc1_en), .acc2_en(acc2_en),
    .first(first), .val(acc1_en ? diff : cur_val), .margin(cfg_margin),
    .mean1(mean1), .mean2(mean2)
  );

  zs_hit_sel #(.VAL_W(VAL_W)) u_hit (
    .val(cur_val), .cm(mean2), .cm_en(cfg_cm_en), .thr(cfg_thr),
    .corr(corr), .hit(hit)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    buf_we  = 1'b0;
    acc1_en = 1'b0;
    acc2_en = 1'b0;
    ov_d    = 1'b0;
    ol_d    = 1'b0;
    oi_d    = oi_q;
    oval_d  = oval_q;
    oraw_d  = oraw_q;
    case (state_q)
      ST_LOAD: begin
        if (accept) begin
          cnt_d = cnt_q + 1'b1;
          if (cfg_raw) begin
            ov_d   = 1'b1;
            ol_d   = last_slot;
            oi_d   = in_idx;
            oval_d = VAL_W'(in_sample);
            oraw_d = 1'b1;
          end else begin
            buf_we  = 1'b1;
            acc1_en = 1'b1;
            if (last_slot) state_d = ST_CLIP;
          end
        end
      end
      ST_CLIP: begin
        acc2_en = 1'b1;
        cnt_d   = cnt_q + 1'b1;
        if (last_slot) state_d = ST_EMIT;
      end
      ST_EMIT: begin
        ov_d   = hit;
        ol_d   = last_slot;
        oi_d   = cur_idx;
        oval_d = corr;
        oraw_d = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (last_slot) state_d = ST_LOAD;
      end
      default: state_d = ST_LOAD;
    endcase
  end

  // Control and output registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      ov_q    <= 1'b0;
      ol_q    <= 1'b0;
      oi_q    <= '0;
      oval_q  <= '0;
      oraw_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ov_q    <= ov_d;
      ol_q    <= ol_d;
      if (ov_d | ol_d) begin
        oi_q   <= oi_d;
        oval_q <= oval_d;
        oraw_q <= oraw_d;
      end
    end
  end

  // Group buffer, datapath only
  always_ff @(posedge clk) begin
    if (buf_we) begin
      val_buf[cnt_q] <= diff;
      idx_buf[cnt_q] <= in_idx;
    end
  end

  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_idx   = oi_q;
  assign out_value = oval_q;

  // R1: bypass forwards the accepted sample one cycle later
  p_raw_pass_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (accept && cfg_raw) |=> (out_valid && out_value == VAL_W'($past(in_sample))));

  // R5: clipping only lowers values, so the final offset is not above the first
  p_mean_order_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_EMIT) |-> (mean2 <= mean1));

  // R6: a forwarded suppression record lies strictly above the threshold
  p_hit_above_thr_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !oraw_q) |-> (out_value > $past(cfg_thr)));

  // R8: a suppression end marker follows the final emit cycle
  p_last_from_emit_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (out_last && !oraw_q) |-> $past(state_q == ST_EMIT && cnt_q == CNT_END));

  // R8: end markers never repeat on consecutive cycles
  p_last_spacing_r8: assert property (@(posedge clk) disable iff (!rst_s)
    out_last |=> !out_last);
endmodule

// File: tb/zs_pipeline_tb.sv
module zs_pipeline_tb;
  localparam int N = 32;

  typedef struct packed {
    logic              raw;
    logic              cm;
    logic [10:0]       margin;
    logic signed [10:0] thr;
    logic [2:0]        pat;
    logic [3:0]        seed;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 11'd0,    11'sd6,    3'd0, 4'd1},  // R2 R3
    '{1'b0, 1'b1, 11'd20,   11'sd6,    3'd1, 4'd2},  // R4 R5
    '{1'b0, 1'b1, 11'd0,    11'sd5,    3'd2, 4'd3},  // R5
    '{1'b1, 1'b0, 11'd0,    11'sd0,    3'd0, 4'd4},  // R1
    '{1'b0, 1'b0, 11'd0,    11'sd6,    3'd3, 4'd0},  // R6
    '{1'b0, 1'b1, 11'd2047, 11'sd100,  3'd4, 4'd0},  // R7
    '{1'b0, 1'b0, 11'd0,    11'sd1000, 3'd0, 4'd5}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_raw = 1'b0, cfg_cm_en = 1'b0;
  logic [10:0] cfg_margin = '0;
  logic signed [10:0] cfg_thr = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_idx = '0;
  logic [9:0] in_sample = '0;
  logic [7:0] ped_addr;
  logic [9:0] ped_data;
  logic out_valid, out_last;
  logic [7:0] out_idx;
  logic signed [10:0] out_value;

  int checks = 0, errors = 0, cycles = 0;
  int smp [N], pix [N];
  int e_valid [64], e_idx [64], e_val [64], e_last [64];
  int g_valid [64], g_idx [64], g_val [64], g_last [64];
  int e_n, g_n;
  bit seen_last = 1'b0;

  always #10 clk = ~clk;

  zs_pipeline u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_raw(cfg_raw), .cfg_cm_en(cfg_cm_en),
    .cfg_margin(cfg_margin), .cfg_thr(cfg_thr), .in_valid(in_valid),
    .in_ready(in_ready), .in_idx(in_idx), .in_sample(in_sample),
    .ped_addr(ped_addr), .ped_data(ped_data), .out_valid(out_valid),
    .out_last(out_last), .out_idx(out_idx), .out_value(out_value)
  );

  function automatic int ped_of(int a);
    return 500 + ((a * 37) % 200);
  endfunction

  assign ped_data = 10'(ped_of(int'(ped_addr)));

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int gen(int pat, int seed, int i, int p);
    int noise, hitp, s;
    noise = ((i * 13 + seed * 5) % 9) - 4;
    hitp  = ((i % 11) == (seed % 11)) ? 1 : 0;
    case (pat)
      0: s = p + noise + hitp * 40;
      1: s = p + 60 + noise + hitp * 200;
      2: s = p - 30 + noise + hitp * 50;
      3: s = p + 6 + (i & 1);
      default: s = (i == 0) ? 1023 : 0;
    endcase
    return clampi(s, 0, 1023);
  endfunction

  function automatic string tag_of(vec_t v);
    if (v.raw) return "R1";
    case (v.pat)
      3'd1: return "R5";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return (v.thr > 11'sd500) ? "R8" : "R2";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_expected(vec_t v);
    int d [N];
    int s1, s2, m1, m2, cm, c;
    e_n = 0;
    if (v.raw) begin
      for (int i = 0; i < N; i++) begin
        e_valid[e_n] = 1; e_idx[e_n] = pix[i]; e_val[e_n] = smp[i];
        e_last[e_n] = (i == N - 1); e_n++;
      end
      return;
    end
    s1 = 0;
    for (int i = 0; i < N; i++) begin
      d[i] = smp[i] - ped_of(pix[i]);
      s1 += d[i];
    end
    m1 = s1 >>> 5;
    s2 = 0;
    for (int i = 0; i < N; i++) s2 += (d[i] > m1 + int'(v.margin)) ? m1 : d[i];
    m2 = s2 >>> 5;
    cm = v.cm ? m2 : 0;
    for (int i = 0; i < N; i++) begin
      c = clampi(d[i] - cm, -1024, 1023);
      if (c > int'(v.thr) || i == N - 1) begin
        e_valid[e_n] = (c > int'(v.thr)); e_idx[e_n] = pix[i]; e_val[e_n] = c;
        e_last[e_n] = (i == N - 1); e_n++;
      end
    end
  endtask

  // Output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (rst_n && (out_valid || out_last) && g_n < 64) begin
      g_valid[g_n] = out_valid; g_idx[g_n] = out_idx;
      g_val[g_n] = out_value;   g_last[g_n] = out_last;
      g_n++;
      if (out_last) seen_last = 1'b1;
    end
  end

  task automatic run_group(int g, vec_t v);
    int busy;
    string tg;
    tg = tag_of(v);
    cfg_raw = v.raw; cfg_cm_en = v.cm; cfg_margin = v.margin; cfg_thr = v.thr;
    for (int i = 0; i < N; i++) begin
      pix[i] = (i * 7 + g * 40) % 256;
      smp[i] = gen(int'(v.pat), int'(v.seed), i, ped_of(pix[i]));
    end
    build_expected(v);
    g_n = 0; seen_last = 1'b0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_idx = 8'(pix[i]); in_sample = 10'(smp[i]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (!v.raw) begin
      busy = 0;
      while (!in_ready) begin busy++; @(negedge clk); end
      chk(busy == 64, "R9", "stall cycles", busy, 64);
    end
    while (!seen_last) @(negedge clk);
    @(negedge clk);
    chk(g_n == e_n, v.raw ? "R1" : "R8", "record count", g_n, e_n);
    for (int k = 0; k < e_n && k < g_n; k++) begin
      chk(g_valid[k] == e_valid[k], tg, "valid", g_valid[k], e_valid[k]);
      chk(g_idx[k] == e_idx[k], "R9", "index order", g_idx[k], e_idx[k]);
      chk(g_val[k] == e_val[k], tg, "value", g_val[k], e_val[k]);
      chk(g_last[k] == e_last[k], "R8", "last flag", g_last[k], e_last[k]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs idle and input open during reset
    chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    chk(out_last == 1'b0, "R10", "out_last in reset", out_last, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    // R2: baseline lookup follows the input index combinationally
    in_idx = 8'd77; #1;
    chk(ped_addr == 8'd77, "R2", "ped_addr", ped_addr, 77);
    chk(int'(ped_data) == ped_of(77), "R2", "ped_data", ped_data, ped_of(77));

    for (int g = 0; g < NVEC; g++) run_group(g, VEC[g]);

    // R3/R7: repeat the saturating pattern with offset removal off
    begin
      vec_t v;
      v = VEC[5];
      v.cm = 1'b0;
      run_group(5, v);
    end
    // R1: bypass directly after a suppression group
    run_group(2, VEC[3]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule